// File: doc/BRIEF.md
# Windowed Threshold Interrupt with Persistence

This block watches a stream of 16-bit conversion results and raises an alarm when the value stays outside a programmable window for long enough. The window edges come from two 8-bit threshold bytes. Each byte is the upper half of a 16-bit bound, and the lower half of that bound is always zero. A result counts as out of window when it is strictly above the upper bound or strictly below the lower bound.

A persistence counter counts consecutive out-of-window results. Once the count reaches the number chosen by a 2-bit persistence code, the block sets a latched interrupt flag. While the flag is set, an open-drain active-low interrupt pin is pulled low. The flag stays set until the host clears it. The host can clear it with a dedicated clear command or by writing zero to the flag. Conversion and the host register path sit outside this block. The block keeps only the two threshold bytes, the counter and the flag.

Top module: `win_irq`

## Requirements
- R1: After reset the flag is 0, the interrupt pin is released (high impedance), the upper threshold byte is 0xFF and the lower threshold byte is 0x00.
- R2: A write with `thr_we[1]` loads the upper byte and a write with `thr_we[0]` loads the lower byte. Each byte becomes bits 15:8 of its bound, with bits 7:0 zero. A result is out of window when it is greater than the upper bound or less than the lower bound. A result equal to a bound is in window.
- R3: Any valid in-window result sets the consecutive count back to zero.
- R4: `persist_sel` values 0, 1, 2 and 3 require 1, 4, 8 and 16 consecutive valid out-of-window results to set the flag. One result fewer does not set it.
- R5: Once set, the flag stays 1 through any number of further results until a clear is applied. The flag becomes visible on the edge that samples the triggering result.
- R6: The flag is cleared by a pulse on `clr_cmd` or by `flag_we` with `flag_wdata` = 0. A write with `flag_wdata` = 1 has no effect on the flag.
- R7: A clear in the same cycle as a trigger leaves the flag set.
- R8: `irq_n` drives 0 while the flag is 1 and is high impedance while it is 0.
- R9: Results presented while `res_valid` is 0 do not change the count or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | Strobe marking a new conversion result |
| res_data | input | 16 | Conversion result |
| thr_we | input | 2 | Threshold write enables: bit 1 upper byte, bit 0 lower byte |
| thr_wdata | input | 8 | Threshold byte to write |
| persist_sel | input | 2 | Persistence code |
| flag_we | input | 1 | Host write to the flag |
| flag_wdata | input | 1 | Value written to the flag; only 0 acts |
| clr_cmd | input | 1 | Dedicated clear-interrupt command |
| irq_flag | output | 1 | Latched interrupt flag |
| irq_n | output | 1 | Open-drain interrupt, low while the flag is set |

## Verification
The first pattern probes the window edges. Results land exactly on each bound and one count past it, first with the reset thresholds and then with programmed ones. This separates a strict comparison from an inclusive one and shows whether the zero low byte is applied. The second pattern is a run of out-of-window results for each persistence code, stopped one short, broken by an in-window result and then completed. This tells a consecutive count from a cumulative one and shows the code mapping. The last patterns cover the clear paths, a clear that collides with a trigger, writes of 1 to the flag, and out-of-window data held without its strobe. These show which inputs can move the flag and which cannot.

// File: rtl/win_irq.sv
module win_irq #(
  parameter int DATA_W    = 16,
  parameter int THR_W     = 8,
  parameter int MAX_RUN   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [1:0]        thr_we,
  input  logic [THR_W-1:0]  thr_wdata,
  input  logic [1:0]        persist_sel,
  input  logic              flag_we,
  input  logic              flag_wdata,
  input  logic              clr_cmd,
  output logic              irq_flag,
  output logic              irq_n
);
  localparam int LOW_W = DATA_W - THR_W;
  localparam int CNT_W = $clog2(MAX_RUN + 1);

  logic [THR_W-1:0] hi_byte, lo_byte;
  logic [CNT_W-1:0] run_cnt, run_inc, run_need;
  logic             above, below, outside, trig, clr;

  assign above   = res_data > {hi_byte, {LOW_W{1'b0}}};
  assign below   = res_data < {lo_byte, {LOW_W{1'b0}}};
  assign outside = above | below;

  always_comb begin
    case (persist_sel)
      2'd0:    run_need = CNT_W'(1);
      2'd1:    run_need = CNT_W'(4);
      2'd2:    run_need = CNT_W'(8);
      default: run_need = CNT_W'(MAX_RUN);
    endcase
  end

  assign run_inc = (run_cnt == CNT_W'(MAX_RUN)) ? run_cnt : run_cnt + 1'b1;
  assign trig    = res_valid & outside & (run_inc >= run_need);
  assign clr     = clr_cmd | (flag_we & ~flag_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_byte <= '1;
      lo_byte <= '0;
    end else begin
      if (thr_we[1]) hi_byte <= thr_wdata;
      if (thr_we[0]) lo_byte <= thr_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_cnt <= '0;
    else if (res_valid) run_cnt <= outside ? run_inc : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    irq_flag <= 1'b0;
    else if (trig) irq_flag <= 1'b1;
    else if (clr)  irq_flag <= 1'b0;
  end

  assign irq_n = irq_flag ? 1'b0 : 1'bz;

  assert_run_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CNT_W'(MAX_RUN));

  assert_inwin_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !outside) |=> (run_cnt == '0));

  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !clr_cmd && !(flag_we && !flag_wdata)) |=> irq_flag);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd && !res_valid) |=> !irq_flag);

  assert_novalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !thr_we[0] && !thr_we[1]) |=> $stable(run_cnt));

  assert_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(res_valid));
endmodule

// File: tb/win_irq_tb_top.sv
module win_irq_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        res_valid = 0;
  logic [15:0] res_data = '0;
  logic [1:0]  thr_we = '0;
  logic [7:0]  thr_wdata = '0;
  logic [1:0]  persist_sel = '0;
  logic        flag_we = 0;
  logic        flag_wdata = 0;
  logic        clr_cmd = 0;
  logic        irq_flag;
  wire         irq_pin;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  pullup (irq_pin);

  always #5 clk = ~clk;

  win_irq dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .persist_sel(persist_sel),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .clr_cmd(clr_cmd),
    .irq_flag(irq_flag), .irq_n(irq_pin)
  );

  task automatic check(input string req, input logic exp_flag);
    logic exp_pin;
    exp_pin = exp_flag ? 1'b0 : 1'b1;
    checks++;
    if (irq_flag !== exp_flag || irq_pin !== exp_pin) begin
      errors++;
      $display("FAIL %s flag=%b pin=%b expected flag=%b pin=%b",
               req, irq_flag, irq_pin, exp_flag, exp_pin);
    end
  endtask

  task automatic send(input logic [15:0] d);
    @(negedge clk); res_valid = 1; res_data = d;
    @(negedge clk); res_valid = 0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr_cmd = 1;
    @(negedge clk); clr_cmd = 0;
  endtask

  task automatic set_thr(input logic [1:0] we, input logic [7:0] b);
    @(negedge clk); thr_we = we; thr_wdata = b;
    @(negedge clk); thr_we = '0;
  endtask

  task automatic t_reset();
    check("R1 reset", 1'b0);
  endtask

  task automatic t_default_thr();
    persist_sel = 2'd0;
    send(16'hFF00); check("R1 default upper equal", 1'b0);
    send(16'h0000); check("R1 default lower zero", 1'b0);
    send(16'hFF01); check("R1 default upper exceeded", 1'b1);
    do_clear();     check("R6 clr_cmd", 1'b0);
  endtask

  task automatic t_prog_thr();
    set_thr(2'b10, 8'h80);
    set_thr(2'b01, 8'h20);
    send(16'h8000); check("R2 upper bound equal", 1'b0);
    send(16'h2000); check("R2 lower bound equal", 1'b0);
    send(16'h80FF); check("R2 upper low byte zero", 1'b1);
    do_clear();
    send(16'h1FFF); check("R2 below lower bound", 1'b1);
    do_clear();     check("R6 clear after lower", 1'b0);
  endtask

  task automatic t_persist(input logic [1:0] code, input int need);
    persist_sel = code;
    send(16'h5000);
    for (int i = 0; i < need - 1; i++) send(16'hF000);
    check("R4 one short", 1'b0);
    send(16'h5000);
    check("R3 in-window breaks run", 1'b0);
    for (int i = 0; i < need - 1; i++) send(16'h0100);
    check("R3 run restarted", 1'b0);
    send(16'hF000);
    check("R4 run complete", 1'b1);
    send(16'h5000); send(16'h5000);
    check("R5 flag held", 1'b1);
    do_clear();
  endtask

  task automatic t_flag_write();
    persist_sel = 2'd0;
    @(negedge clk); flag_we = 1; flag_wdata = 1;
    @(negedge clk); flag_we = 0;
    check("R6 write 1 on clear flag", 1'b0);
    send(16'hFFFF);
    @(negedge clk); flag_we = 1; flag_wdata = 1;
    @(negedge clk); flag_we = 0;
    check("R6 write 1 on set flag", 1'b1);
    @(negedge clk); flag_we = 1; flag_wdata = 0;
    @(negedge clk); flag_we = 0;
    check("R6 write 0 clears", 1'b0);
  endtask

  task automatic t_collide();
    persist_sel = 2'd0;
    @(negedge clk); res_valid = 1; res_data = 16'hFFFF; clr_cmd = 1;
    @(negedge clk); res_valid = 0; clr_cmd = 0;
    check("R7 trigger beats clr_cmd", 1'b1);
    @(negedge clk); res_valid = 1; res_data = 16'hFFFF; flag_we = 1; flag_wdata = 0;
    @(negedge clk); res_valid = 0; flag_we = 0;
    check("R7 trigger beats flag write", 1'b1);
    do_clear();
    check("R8 pin released", 1'b0);
  endtask

  task automatic t_novalid();
    persist_sel = 2'd1;
    send(16'h5000);
    send(16'hFFFF); send(16'hFFFF); send(16'hFFFF);
    @(negedge clk); res_data = 16'h5000;
    repeat (5) @(negedge clk);
    res_data = 16'hFFFF;
    repeat (5) @(negedge clk);
    check("R9 data without strobe", 1'b0);
    send(16'hFFFF);
    check("R9 run kept across idle", 1'b1);
    do_clear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_default_thr();
    t_prog_thr();
    t_persist(2'd0, 1);
    t_persist(2'd1, 4);
    t_persist(2'd2, 8);
    t_persist(2'd3, 16);
    t_flag_write();
    t_collide();
    t_novalid();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200us;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired flag=%b expected run to finish", irq_flag);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule